// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller for a processor datapath that spends several clock cycles on each instruction and reuses one memory, one ALU and one register file across those cycles. It watches the 6-bit opcode held in the datapath's instruction register and the ALU zero flag. On every cycle it drives the memory read and write strobes, the instruction-register load, the unconditional and conditional PC loads, the register-file write, the datapath multiplexer selects and a 2-bit ALU operation class that a separate ALU decoder expands.

Every instruction starts with the same two cycles. The first cycle fetches the instruction word and advances the PC by four. The second cycle reads the source registers and computes a branch target ahead of time. The sequencer then takes a path chosen by the opcode class. Word loads take five cycles in total, word stores and register-type operations take four, and branch-if-equal and jump take three. An opcode the sequencer does not know returns to fetch after the shared cycles and writes nothing. The selects are decoded from the state register. The write enables are held low while reset is asserted.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high, `mem_rd_o`, `mem_wr_o`, `ir_wr_o`, `pc_wr_o`, `pc_wr_cond_o`, `reg_wr_o` and `pc_en_o` are all 0. The first cycle after `rst` falls is a fetch cycle.
- R2: A fetch cycle has `mem_rd_o`=1, `ir_wr_o`=1, `pc_wr_o`=1, `addr_sel_o`=0 (PC), `alu_a_sel_o`=0 (PC), `alu_b_sel_o`=1 (constant 4), `alu_op_o`=0 (add) and `pc_src_o`=0 (ALU result).
- R3: The cycle after every fetch is a decode cycle. It has every enable at 0, `alu_a_sel_o`=0, `alu_b_sel_o`=3 (shifted immediate) and `alu_op_o`=0.
- R4: Opcode 0x23 (load) takes 5 cycles. Its third cycle has `alu_a_sel_o`=1 (A), `alu_b_sel_o`=2 (immediate) and add. One later cycle reads memory with `addr_sel_o`=1 (ALUOut). One cycle writes a register with `reg_dst_o`=0 (rt field) and `wb_sel_o`=1 (memory data).
- R5: Opcode 0x2B (store) takes 4 cycles. It has the same address cycle as R4 and exactly one `mem_wr_o` cycle, with `addr_sel_o`=1 and no register write.
- R6: Opcode 0x00 (register-type) takes 4 cycles. One cycle has `alu_op_o`=2 (function field), `alu_a_sel_o`=1 and `alu_b_sel_o`=0 (B). One register write follows with `reg_dst_o`=1 (rd field) and `wb_sel_o`=0 (ALUOut).
- R7: Opcode 0x04 (branch-if-equal) takes 3 cycles. Its last cycle has `alu_op_o`=1 (subtract), A and B selected, `pc_wr_cond_o`=1 and `pc_src_o`=1 (ALUOut). The PC is loaded after fetch only when `zero_i` is 1.
- R8: Opcode 0x02 (jump) takes 3 cycles. Its last cycle has `pc_wr_o`=1 and `pc_src_o`=2 (jump target), whatever the value of `zero_i`.
- R9: Any other opcode takes 2 cycles and asserts no enable after its fetch cycle.
- R10: `pc_en_o` equals `pc_wr_o` OR (`pc_wr_cond_o` AND `zero_i`) in the same cycle. `zero_i` has no effect outside a branch compare.
- R11: At most one of `mem_wr_o`, `reg_wr_o` and `ir_wr_o` is high in any cycle. Every last cycle of an instruction (store write, register write, branch, jump) is followed by a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| zero_i | input | 1 | ALU zero flag |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| ir_wr_o | output | 1 | Instruction register load |
| pc_wr_o | output | 1 | Unconditional PC load |
| pc_wr_cond_o | output | 1 | PC load qualified by zero |
| pc_en_o | output | 1 | Combined PC load enable |
| reg_wr_o | output | 1 | Register file write |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALUOut |
| reg_dst_o | output | 1 | Write register: 0 rt, 1 rd |
| wb_sel_o | output | 1 | Write data: 0 ALUOut, 1 memory data |
| alu_a_sel_o | output | 1 | ALU A input: 0 PC, 1 A |
| alu_b_sel_o | output | 2 | ALU B input: 0 B, 1 four, 2 immediate, 3 shifted immediate |
| alu_op_o | output | 2 | 0 add, 1 subtract, 2 function field |
| pc_src_o | output | 2 | PC source: 0 ALU, 1 ALUOut, 2 jump target |

## Verification
A wrong state appears at the ports on the cycle after the faulty transition. It shows up as a misplaced enable, a wrong select pattern, or an instruction that does not return to fetch after its expected number of cycles. The bench sweeps all 64 opcodes with the zero flag at both values. For each instruction it measures the length and counts every strobe. It also checks the selects in the cycles where they matter. A wrong transition is therefore seen within one instruction, at most five cycles. A stuck or misrouted path also changes every later fetch. A reset asserted in the middle of a load checks the masking of the enables and the return to fetch.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_ADDR, S_LDRD, S_LDWB,
    S_STWR, S_REXE, S_RWB, S_BEQ, S_JMP
  } st_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       reg_wr;
    logic       addr_sel;
    logic       reg_dst;
    logic       wb_sel;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic [1:0] pc_src;
  } ctl_t;

  localparam logic [1:0] ALU_ADD = 2'd0;
  localparam logic [1:0] ALU_SUB = 2'd1;
  localparam logic [1:0] ALU_FN  = 2'd2;
  localparam logic [1:0] B_REG   = 2'd0;
  localparam logic [1:0] B_FOUR  = 2'd1;
  localparam logic [1:0] B_IMM   = 2'd2;
  localparam logic [1:0] B_IMMSH = 2'd3;
  localparam logic [1:0] PC_ALU  = 2'd0;
  localparam logic [1:0] PC_OUT  = 2'd1;
  localparam logic [1:0] PC_JMP  = 2'd2;
endpackage

// File: rtl/ctrl_next_state.sv
module ctrl_next_state
  import mcc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_LW  = 6'h23,
  parameter logic [OP_W-1:0] OP_SW  = 6'h2B,
  parameter logic [OP_W-1:0] OP_RT  = 6'h00,
  parameter logic [OP_W-1:0] OP_BEQ = 6'h04,
  parameter logic [OP_W-1:0] OP_J   = 6'h02
) (
  input  st_e             cur_i,
  input  logic [OP_W-1:0] op_i,
  output st_e             nxt_o
);
  always_comb begin
    nxt_o = S_FETCH;
    unique case (cur_i)
      S_FETCH:  nxt_o = S_DECODE;
      S_DECODE: begin
        if (op_i == OP_LW || op_i == OP_SW) nxt_o = S_ADDR;
        else if (op_i == OP_RT)             nxt_o = S_REXE;
        else if (op_i == OP_BEQ)            nxt_o = S_BEQ;
        else if (op_i == OP_J)              nxt_o = S_JMP;
        else                                nxt_o = S_FETCH;
      end
      S_ADDR:   nxt_o = (op_i == OP_LW) ? S_LDRD : S_STWR;
      S_LDRD:   nxt_o = S_LDWB;
      S_REXE:   nxt_o = S_RWB;
      default:  nxt_o = S_FETCH;
    endcase
  end
endmodule

// File: rtl/ctrl_out_decode.sv
module ctrl_out_decode
  import mcc_pkg::*;
(
  input  st_e  st_i,
  output ctl_t ctl_o
);
  always_comb begin
    ctl_o = '0;
    unique case (st_i)
      S_FETCH: begin
        ctl_o.mem_rd    = 1'b1;
        ctl_o.ir_wr     = 1'b1;
        ctl_o.pc_wr     = 1'b1;
        ctl_o.alu_b_sel = B_FOUR;
        ctl_o.alu_op    = ALU_ADD;
        ctl_o.pc_src    = PC_ALU;
      end
      S_DECODE: begin
        ctl_o.alu_b_sel = B_IMMSH;
        ctl_o.alu_op    = ALU_ADD;
      end
      S_ADDR: begin
        ctl_o.alu_a_sel = 1'b1;
        ctl_o.alu_b_sel = B_IMM;
        ctl_o.alu_op    = ALU_ADD;
      end
      S_LDRD: begin
        ctl_o.mem_rd   = 1'b1;
        ctl_o.addr_sel = 1'b1;
      end
      S_LDWB: begin
        ctl_o.reg_wr  = 1'b1;
        ctl_o.reg_dst = 1'b0;
        ctl_o.wb_sel  = 1'b1;
      end
      S_STWR: begin
        ctl_o.mem_wr   = 1'b1;
        ctl_o.addr_sel = 1'b1;
      end
      S_REXE: begin
        ctl_o.alu_a_sel = 1'b1;
        ctl_o.alu_b_sel = B_REG;
        ctl_o.alu_op    = ALU_FN;
      end
      S_RWB: begin
        ctl_o.reg_wr  = 1'b1;
        ctl_o.reg_dst = 1'b1;
        ctl_o.wb_sel  = 1'b0;
      end
      S_BEQ: begin
        ctl_o.alu_a_sel  = 1'b1;
        ctl_o.alu_b_sel  = B_REG;
        ctl_o.alu_op     = ALU_SUB;
        ctl_o.pc_wr_cond = 1'b1;
        ctl_o.pc_src     = PC_OUT;
      end
      S_JMP: begin
        ctl_o.pc_wr  = 1'b1;
        ctl_o.pc_src = PC_JMP;
      end
      default: ctl_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mcc_pkg::*;
#(
  parameter int OP_W = 6,
  parameter logic [OP_W-1:0] OP_LW  = 6'h23,
  parameter logic [OP_W-1:0] OP_SW  = 6'h2B,
  parameter logic [OP_W-1:0] OP_RT  = 6'h00,
  parameter logic [OP_W-1:0] OP_BEQ = 6'h04,
  parameter logic [OP_W-1:0] OP_J   = 6'h02
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode_i,
  input  logic            zero_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            ir_wr_o,
  output logic            pc_wr_o,
  output logic            pc_wr_cond_o,
  output logic            pc_en_o,
  output logic            reg_wr_o,
  output logic            addr_sel_o,
  output logic            reg_dst_o,
  output logic            wb_sel_o,
  output logic            alu_a_sel_o,
  output logic [1:0]      alu_b_sel_o,
  output logic [1:0]      alu_op_o,
  output logic [1:0]      pc_src_o
);
  st_e  st_q, st_d;
  ctl_t ctl;

  ctrl_next_state #(
    .OP_W(OP_W), .OP_LW(OP_LW), .OP_SW(OP_SW),
    .OP_RT(OP_RT), .OP_BEQ(OP_BEQ), .OP_J(OP_J)
  ) u_next (
    .cur_i(st_q),
    .op_i (opcode_i),
    .nxt_o(st_d)
  );

  ctrl_out_decode u_dec (
    .st_i (st_q),
    .ctl_o(ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) st_q <= S_FETCH;
    else     st_q <= st_d;
  end

  // Enables are gated by reset; selects pass straight through.
  assign mem_rd_o     = ctl.mem_rd     & ~rst;
  assign mem_wr_o     = ctl.mem_wr     & ~rst;
  assign ir_wr_o      = ctl.ir_wr      & ~rst;
  assign pc_wr_o      = ctl.pc_wr      & ~rst;
  assign pc_wr_cond_o = ctl.pc_wr_cond & ~rst;
  assign reg_wr_o     = ctl.reg_wr     & ~rst;
  assign pc_en_o      = pc_wr_o | (pc_wr_cond_o & zero_i);
  assign addr_sel_o   = ctl.addr_sel;
  assign reg_dst_o    = ctl.reg_dst;
  assign wb_sel_o     = ctl.wb_sel;
  assign alu_a_sel_o  = ctl.alu_a_sel;
  assign alu_b_sel_o  = ctl.alu_b_sel;
  assign alu_op_o     = ctl.alu_op;
  assign pc_src_o     = ctl.pc_src;

  // R1: enables quiet while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> !(mem_rd_o || mem_wr_o || ir_wr_o || pc_wr_o || pc_wr_cond_o || reg_wr_o));

  // R1: release of reset lands in fetch
  a_r1_release_fetch: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ir_wr_o && mem_rd_o && pc_wr_o));

  // R3: the cycle after fetch is decode
  a_r3_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    ir_wr_o |=> (!ir_wr_o && !mem_rd_o && !pc_wr_o && alu_b_sel_o == B_IMMSH && !alu_a_sel_o));

  // R11: single write target per cycle
  a_r11_one_write: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr_o, reg_wr_o, ir_wr_o}));

  // R11: terminal cycles are followed by fetch
  a_r11_store_returns: assert property (@(posedge clk) disable iff (rst)
    mem_wr_o |=> ir_wr_o);
  a_r11_regwr_returns: assert property (@(posedge clk) disable iff (rst)
    reg_wr_o |=> ir_wr_o);
  a_r11_branch_returns: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_cond_o || (pc_wr_o && pc_src_o == PC_JMP)) |=> ir_wr_o);

  // R7: conditional PC load only in a subtracting compare
  a_r7_cond_with_sub: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond_o |-> (alu_op_o == ALU_SUB && pc_src_o == PC_OUT));
endmodule

// File: tb/test_mc_ctrl_fsm.sv
`timescale 1ns/1ps
module test_mc_ctrl_fsm;
  localparam int OP_W = 6;
  localparam logic [OP_W-1:0] C_LW = 6'h23, C_SW = 6'h2B, C_RT = 6'h00,
                              C_BEQ = 6'h04, C_J = 6'h02;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [OP_W-1:0] opcode = '0;
  logic zero = 1'b0;
  logic mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_en, reg_wr;
  logic addr_sel, reg_dst, wb_sel, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mc_ctrl_fsm i_mc_ctrl_fsm (
    .clk(clk), .rst(rst), .opcode_i(opcode), .zero_i(zero),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .ir_wr_o(ir_wr), .pc_wr_o(pc_wr),
    .pc_wr_cond_o(pc_wr_cond), .pc_en_o(pc_en), .reg_wr_o(reg_wr),
    .addr_sel_o(addr_sel), .reg_dst_o(reg_dst), .wb_sel_o(wb_sel),
    .alu_a_sel_o(alu_a_sel), .alu_b_sel_o(alu_b_sel), .alu_op_o(alu_op),
    .pc_src_o(pc_src)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (op %h zero %0b)", req, act, exp, opcode, zero);
    end
  endtask

  function automatic int enables();
    return int'({mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, reg_wr, pc_en});
  endfunction

  // Called at a negedge in a fetch cycle.
  task automatic run_instr(input logic [OP_W-1:0] op, input logic z);
    int len = 1;
    int nmw = 0, nrw = 0, nrd = 0, npc = 0;
    bit addr_ok = 1'b1, dst = 1'b0, wb = 1'b0;
    bit saw_adr = 1'b0, saw_fn = 1'b0, saw_sub = 1'b0, saw_jmp = 1'b0, any_en = 1'b0;
    int e_len, e_mw, e_rw, e_rd, e_pc;
    string tag;
    opcode = op;
    zero = z;
    #1;
    chk(mem_rd && ir_wr && pc_wr && !addr_sel && !alu_a_sel && alu_b_sel == 2'd1 &&
        alu_op == 2'd0 && pc_src == 2'd0, "R2 fetch", int'({alu_b_sel, pc_src}), 4);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (ir_wr) break;
      len++;
      if (len == 2)
        chk(enables() == 0 && !alu_a_sel && alu_b_sel == 2'd3 && alu_op == 2'd0,
            "R3 decode", int'({alu_a_sel, alu_b_sel, alu_op}), 12);
      else if (enables() != 0) any_en = 1'b1;
      if (len == 3 && alu_a_sel && alu_b_sel == 2'd2 && alu_op == 2'd0) saw_adr = 1'b1;
      if (mem_wr) begin nmw++; if (!addr_sel) addr_ok = 1'b0; end
      if (mem_rd) begin nrd++; if (!addr_sel) addr_ok = 1'b0; end
      if (reg_wr) begin nrw++; dst = reg_dst; wb = wb_sel; end
      if (pc_en) npc++;
      if (alu_op == 2'd2 && alu_a_sel && alu_b_sel == 2'd0) saw_fn = 1'b1;
      if (alu_op == 2'd1 && alu_a_sel && alu_b_sel == 2'd0 && pc_wr_cond && pc_src == 2'd1)
        saw_sub = 1'b1;
      if (pc_wr && pc_src == 2'd2) saw_jmp = 1'b1;
    end
    e_mw = 0; e_rw = 0; e_rd = 0; e_pc = 0;
    case (op)
      C_LW:  begin tag = "R4 load";   e_len = 5; e_rw = 1; e_rd = 1; end
      C_SW:  begin tag = "R5 store";  e_len = 4; e_mw = 1; end
      C_RT:  begin tag = "R6 regop";  e_len = 4; e_rw = 1; end
      C_BEQ: begin tag = "R7 branch"; e_len = 3; e_pc = z ? 1 : 0; end
      C_J:   begin tag = "R8 jump";   e_len = 3; e_pc = 1; end
      default: begin tag = "R9 other"; e_len = 2; end
    endcase
    chk(len == e_len, {tag, " length"}, len, e_len);
    chk(nmw == e_mw, {tag, " mem writes"}, nmw, e_mw);
    chk(nrw == e_rw, {tag, " reg writes"}, nrw, e_rw);
    chk(nrd == e_rd, {tag, " mem reads"}, nrd, e_rd);
    chk(npc == e_pc, {tag, " R10 pc loads"}, npc, e_pc);
    chk(addr_ok, {tag, " address select"}, 0, 1);
    case (op)
      C_LW: begin
        chk(saw_adr, "R4 address cycle", 0, 1);
        chk(!dst && wb, "R4 writeback selects", int'({dst, wb}), 1);
      end
      C_SW: chk(saw_adr, "R5 address cycle", 0, 1);
      C_RT: begin
        chk(saw_fn, "R6 function execute", 0, 1);
        chk(dst && !wb, "R6 writeback selects", int'({dst, wb}), 2);
      end
      C_BEQ: chk(saw_sub, "R7 compare cycle", 0, 1);
      C_J:   chk(saw_jmp, "R8 jump target", 0, 1);
      default: chk(!any_en, "R9 no enables", int'(any_en), 0);
    endcase
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(enables() == 0, "R1 reset quiet", enables(), 0);
    rst = 1'b0;
    #1;
    chk(ir_wr && mem_rd && pc_wr, "R1 fetch after reset", int'(ir_wr), 1);
    for (int z = 0; z < 2; z++)
      for (int o = 0; o < 64; o++)
        run_instr(o[OP_W-1:0], z[0]);
    // Back-to-back known classes with zero toggling (R10, R11)
    run_instr(C_BEQ, 1'b1);
    run_instr(C_BEQ, 1'b0);
    run_instr(C_J, 1'b0);
    run_instr(C_LW, 1'b1);
    // Reset in the middle of a load (R1)
    opcode = C_LW;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    #1;
    chk(enables() == 0, "R1 reset mid-load quiet", enables(), 0);
    repeat (2) @(negedge clk);
    chk(enables() == 0, "R1 reset held quiet", enables(), 0);
    rst = 1'b0;
    #1;
    chk(ir_wr && mem_rd && pc_wr && alu_b_sel == 2'd1, "R1 restart in fetch", int'(ir_wr), 1);
    run_instr(C_SW, 1'b0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule